// File: doc/BRIEF.md
# Sawtooth-Timer Watchdog Monitor

This block watches a heartbeat signal produced by a microcontroller and requests a system reset when the heartbeat stops. The timing element is an up/down counter that behaves like a timing capacitor. It falls slowly between an upper and a lower threshold. It climbs four times faster on the way back up. The result is a sawtooth. A rising heartbeat edge seen during the fall turns the ramp around, so a healthy software loop keeps the counter away from the lower threshold.

When the counter reaches the lower threshold, the block drives its active-low reset request. The request stays low while the counter climbs back to the upper threshold, so the pulse width equals the recharge time. The heartbeat input is asynchronous and passes through a two-flop synchronizer before its rising edge is detected. When the enable input is low, the ramp is parked at the upper threshold and no request is produced. The request is meant to be ANDed with an undervoltage reset outside the block.

Top module: `sawtooth_wdt`

## Requirements
- R1: In the clock cycle after the synchronous reset input `rst_n` is sampled low, `wd_rst_n` is high. The ramp then sits at the upper threshold in the falling phase. This also holds when reset is applied in the middle of a reset pulse.
- R2: With `wd_en` high and no heartbeat edge, the counter falls by DN_STEP (1) per clock. `wd_rst_n` stays high for 33 clocks after reset release and goes low after the 34th clock: (HI_TH-LO_TH)/DN_STEP with the defaults 47 and 13.
- R3: While climbing, the counter rises by UP_STEP (4) per clock. It is clamped to HI_TH on the clock where the next step would reach or pass HI_TH, and that same clock restarts the fall.
- R4: After a timeout, `wd_rst_n` stays low for the whole climb from LO_TH to HI_TH, which is 9 clocks with the defaults. It then goes high, and the next timeout follows 34 clocks later.
- R5: A rising edge on `hb_in` (low then high, each held for at least two clocks) is resynchronized through two flops. On the third clock edge after the edge is first sampled, the ramp turns from falling to climbing without changing the count and without a reset request.
- R6: Rising edges on `hb_in` whose detected edge falls within the climbing phase are ignored. They do not change the width of a reset pulse or the time of the next timeout.
- R7: While `wd_en` is low, `wd_rst_n` is high from the first clock after `wd_en` is sampled low. This also ends any active pulse.
- R8: When `wd_en` returns high, the ramp starts again from the upper threshold in the falling phase, so the first timeout occurs after the 34th clock.
- R9: A heartbeat whose rising edges come every 20 clocks keeps `wd_rst_n` high indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hb_in | input | 1 | Asynchronous heartbeat from the supervised processor |
| wd_en | input | 1 | Watchdog enable; high runs the ramp |
| wd_rst_n | output | 1 | Active-low watchdog reset request, registered |

## Verification
The embedded properties check on every cycle the following: the count stays within the thresholds, each falling and climbing clock moves by the exact step, a detected edge during the fall turns the ramp with the count held, the request is only active while climbing, and a low enable always clears the request. The count of clocks to the first timeout, the pulse width, and the timing after a turnaround that depends on the 4:1 ratio appear only in the bench scenarios, which count clock edges from reset release or from enable. The same holds for ignoring heartbeat edges during a pulse and for the effect of a steady heartbeat over a long run.

// File: rtl/swdt_pkg.sv
// Package for the sawtooth watchdog.
// Holds the ramp direction type that the core and its checks share.
package swdt_pkg;
    typedef enum logic {
        PH_FALL = 1'b0,   // slow decrement toward the lower threshold
        PH_RISE = 1'b1    // fast increment toward the upper threshold
    } ramp_phase_e;
endpackage

// File: rtl/swdt_hb_sync.sv
// Heartbeat synchronizer and rising-edge detector.
// Assumes hb_in is asynchronous to clk. It passes through STAGES flops,
// then a delayed copy gives a single-cycle rise pulse. Active-low sync reset.
module swdt_hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_in,
    output logic hb_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw heartbeat through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], hb_in};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign hb_rise = sync_q[STAGES-1] & ~prev_q;

    // R5
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hb_rise |-> $past(sync_q[STAGES-2]));

    // R5
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hb_rise |=> !hb_rise);
endmodule

// File: rtl/swdt_ramp_core.sv
// Sawtooth ramp: an up/down counter that falls by DN_STEP and climbs by
// UP_STEP between LO_TH and HI_TH. Assumes LO_TH < HI_TH < 2**CNT_W and a
// one-cycle hb_rise pulse. Reaching LO_TH raises the timeout flag. The flag
// holds until the climb hits HI_TH. Reset or a low enable parks the ramp at
// HI_TH in the falling phase.
module swdt_ramp_core
    import swdt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int LO_TH   = 13,
    parameter int HI_TH   = 47,
    parameter int DN_STEP = 1,
    parameter int UP_STEP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hb_rise,
    output logic tmo
);
    localparam int CALC_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    ramp_phase_e       phase_q;
    logic              tmo_q;
    logic [CALC_W-1:0] up_sum;
    logic              at_floor;
    logic              at_ceiling;

    // Next-step arithmetic and threshold compares, one bit wider than the count.
    always_comb begin
        up_sum     = {1'b0, cnt_q} + CALC_W'(UP_STEP);
        at_floor   = ({1'b0, cnt_q} <= CALC_W'(LO_TH + DN_STEP));
        at_ceiling = (up_sum >= CALC_W'(HI_TH));
    end

    // Ramp state machine: count, direction and timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q   <= CNT_W'(HI_TH);
            phase_q <= PH_FALL;
            tmo_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_FALL: begin
                    if (hb_rise) begin
                        phase_q <= PH_RISE;
                    end else if (at_floor) begin
                        cnt_q   <= CNT_W'(LO_TH);
                        phase_q <= PH_RISE;
                        tmo_q   <= 1'b1;
                    end else begin
                        cnt_q   <= cnt_q - CNT_W'(DN_STEP);
                    end
                end
                default: begin
                    if (at_ceiling) begin
                        cnt_q   <= CNT_W'(HI_TH);
                        phase_q <= PH_FALL;
                        tmo_q   <= 1'b0;
                    end else begin
                        cnt_q   <= up_sum[CNT_W-1:0];
                    end
                end
            endcase
        end
    end

    assign tmo = tmo_q;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= CNT_W'(LO_TH)) && (cnt_q <= CNT_W'(HI_TH)));

    // R2
    fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_q == PH_FALL && !hb_rise && cnt_q > CNT_W'(LO_TH + DN_STEP))
        |=> (cnt_q == $past(cnt_q) - CNT_W'(DN_STEP)) && (phase_q == PH_FALL));

    // R6 (and R3): the climb step does not depend on heartbeat edges
    rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_q == PH_RISE && ({1'b0, cnt_q} + CALC_W'(UP_STEP) < CALC_W'(HI_TH)))
        |=> (cnt_q == $past(cnt_q) + CNT_W'(UP_STEP)) && (phase_q == PH_RISE));

    // R5
    turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_q == PH_FALL && hb_rise)
        |=> (phase_q == PH_RISE) && !tmo_q && (cnt_q == $past(cnt_q)));

    // R4
    tmo_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> (phase_q == PH_RISE));
endmodule

// File: rtl/sawtooth_wdt.sv
// Sawtooth-timer watchdog top level. It chains the heartbeat synchronizer
// to the ramp core and inverts the timeout flag into an active-low request.
// The request comes straight from a flop, so it is glitch-free for the
// AND with the undervoltage reset outside the block.
module sawtooth_wdt #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8,
    parameter int LO_TH       = 13,
    parameter int HI_TH       = 47,
    parameter int DN_STEP     = 1,
    parameter int UP_STEP     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_in,
    input  logic wd_en,
    output logic wd_rst_n
);
    logic hb_rise;
    logic tmo;

    swdt_hb_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .hb_in   (hb_in),
        .hb_rise (hb_rise)
    );

    swdt_ramp_core #(
        .CNT_W   (CNT_W),
        .LO_TH   (LO_TH),
        .HI_TH   (HI_TH),
        .DN_STEP (DN_STEP),
        .UP_STEP (UP_STEP)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wd_en),
        .hb_rise (hb_rise),
        .tmo     (tmo)
    );

    assign wd_rst_n = ~tmo;

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> wd_rst_n);

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> wd_rst_n);
endmodule

// File: tb/sawtooth_wdt_tb.sv
`timescale 1ns/1ps
module sawtooth_wdt_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb_in = 1'b0;
    logic wd_en = 1'b1;
    logic wd_rst_n;

    int cyc = 0;
    int t0 = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sawtooth_wdt u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .hb_in    (hb_in),
        .wd_en    (wd_en),
        .wd_rst_n (wd_rst_n)
    );

    // Free-running timeout table, edges counted from reset release.
    // R2: timeout after edge 34; R4: 9-clock pulse, next timeout 34 later;
    // R3: the climb of 4 per clock sets the 9-clock width.
    localparam int VEC_N = 10;
    localparam int VEC_EDGE [VEC_N] = '{1, 33, 34, 35, 42, 43, 76, 77, 85, 86};
    localparam bit VEC_EXP  [VEC_N] = '{1,  1,  0,  0,  0,  1,  1,  0,  0,  1};
    localparam int VEC_REQ  [VEC_N] = '{2,  2,  2,  4,  3,  4,  4,  4,  3,  4};

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at edge %0d: wd_rst_n=%b expected %b", req, cyc - t0, act, exp);
        end
    endtask

    // Wait until the negedge that follows edge n after the marker t0.
    task automatic step_to(input int n);
        while (cyc < t0 + n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hb_in = 1'b0;
        wd_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t0 = cyc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", wd_rst_n, 1'b1);
        rst_n = 1'b1;
        t0 = cyc;

        // Table walk: free-running ramp with no heartbeat
        for (int i = 0; i < VEC_N; i++) begin
            step_to(VEC_EDGE[i]);
            check($sformatf("R%0d", VEC_REQ[i]), wd_rst_n, VEC_EXP[i]);
        end

        // R1: reset applied in the middle of a pulse releases the request
        do_reset();
        step_to(36);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", wd_rst_n, 1'b1);

        // R6: a heartbeat edge detected during the climb is ignored
        do_reset();
        step_to(35);
        hb_in = 1'b1;
        step_to(38);
        hb_in = 1'b0;
        step_to(42);
        check("R6", wd_rst_n, 1'b0);
        step_to(43);
        check("R6", wd_rst_n, 1'b1);
        step_to(76);
        check("R6", wd_rst_n, 1'b1);
        step_to(77);
        check("R6", wd_rst_n, 1'b0);

        // R5 / R3: the edge turns the ramp at count 35 on edge 13; the climb
        // is 39, 43, then clamped to 47 on edge 16; the timeout comes at edge 50
        do_reset();
        step_to(10);
        hb_in = 1'b1;
        step_to(20);
        hb_in = 1'b0;
        step_to(34);
        check("R5", wd_rst_n, 1'b1);
        step_to(49);
        check("R3", wd_rst_n, 1'b1);
        step_to(50);
        check("R3", wd_rst_n, 1'b0);

        // R9: a heartbeat every 20 clocks for 300 clocks keeps the request high
        do_reset();
        begin
            logic seen_low;
            seen_low = 1'b0;
            for (int k = 1; k <= 300; k++) begin
                step_to(k);
                hb_in = ((k % 20) >= 10);
                if (wd_rst_n !== 1'b1) seen_low = 1'b1;
            end
            check("R9", seen_low ? 1'b0 : 1'b1, 1'b1);
            hb_in = 1'b0;
        end

        // R7: dropping enable during a pulse releases it on the next clock
        do_reset();
        step_to(36);
        check("R7", wd_rst_n, 1'b0);
        wd_en = 1'b0;
        step_to(37);
        check("R7", wd_rst_n, 1'b1);
        begin
            logic seen_low;
            seen_low = 1'b0;
            for (int k = 38; k <= 140; k++) begin
                step_to(k);
                if (wd_rst_n !== 1'b1) seen_low = 1'b1;
            end
            check("R7", seen_low ? 1'b0 : 1'b1, 1'b1);
        end

        // R8: re-enable starts the ramp again from the top
        wd_en = 1'b1;
        t0 = cyc;
        step_to(33);
        check("R8", wd_rst_n, 1'b1);
        step_to(34);
        check("R8", wd_rst_n, 1'b0);

        finish_run();
    end
endmodule